// File: doc/BRIEF.md
# Multi-Channel Window Checker Register and Interrupt Controller

This block holds the control and status registers of a multi-channel display window checker. It contains the global enable and clock-polarity settings, the interrupt masks, the per-channel window configuration, and the sticky status bits. Software reaches all of these through a simple word-addressed register bus. The checksum datapath is outside this block. In its place, each channel has a one-cycle fail pulse input and the frame boundary arrives as a one-cycle VSYNC pulse. The block turns those pulses into sticky status bits and drives a single level interrupt.

Two lock mechanisms protect the configuration once it is set up. Software can set a freeze bit, and only a reset clears it. The mask register has one freeze bit that guards the two interrupt masks. Each channel has its own freeze bit that guards the rest of that channel's configuration.

A function-alive status bit shows that frames are arriving. It sets on the second VSYNC after the global enable goes high. Dropping the enable restarts that count.

Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The bus has no back-pressure: every access completes in its own cycle. All pulse inputs are synchronous to `clk`.

Top module: `win_chk_ctrl`

## Requirements
- R1: Control is at word address 0. Bit 0 is the global enable, driven on `glb_enable`. Bit 7 inverts the pixel clock, driven on `clk_invert`. All other bits read 0, and everything is 0 after reset.
- R2: Channel c (0..NUM_CH-1) occupies word addresses 4*(c+1)+0..3, which are the byte offsets 0x10 + 0x10*c.
  - Word 0 holds enable [31], freeze [30], start row [27:16] and start column [12:0].
  - Word 1 holds end row [27:16] and end column [12:0].
  - Word 2 is the 32-bit reference value and word 3 is the 32-bit result value.
  - Unlisted bits read 0. The enable bit drives `chan_enable[c]`.
- R3: A `fail_pulse[c]` sets sticky status bit c (status word, address 2) only while both the global enable and the channel enable are 1. Otherwise the pulse is ignored.
- R4: Writing 1 to a status bit c or to bit 17 clears it. Writing 0 leaves it unchanged.
- R5: If a hardware set and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R6: Status bit 16 is read-only and equals the OR of all channel fail bits. Writing it has no effect.
- R7: Status bit 17 sets on the second VSYNC pulse seen while the global enable is 1.
- R8: Clearing the global enable resets the VSYNC count, so after re-enabling, two fresh VSYNC pulses are needed.
- R9: `irq` = (bit16 AND error mask) OR (bit17 AND function mask). The mask word is at address 1: error mask is bit 0, function mask is bit 1, and mask freeze is bit 3.
- R10: While mask freeze is 1, writes cannot change the error mask or the function mask.
- R11: While a channel's freeze bit is 1, writes cannot change any other field in that channel's four words.
- R12: Writing 0 does not clear a freeze bit; only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| vsync | input | 1 | Frame boundary pulse |
| fail_pulse | input | NUM_CH | Per-channel mismatch pulse |
| glb_enable | output | 1 | Global enable |
| clk_invert | output | 1 | Pixel clock inversion |
| chan_enable | output | NUM_CH | Per-channel enable |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, assertions check the following:
- A gated fail pulse always leaves its status bit set, even when a clear arrives in the same cycle.
- A status bit only drops after a write-1 clear.
- The function bit only rises while enabled.
- Freeze bits never fall.
- Frozen masks and frozen channel fields stay stable.

Only the bench scenarios can show the rest:
- The register layout.
- The exact VSYNC count, including the restart after the enable drops.
- The interrupt equation.
- That write-0 and read-only writes leave state unchanged.

// File: rtl/win_chk_pkg.sv
package win_chk_pkg;
  localparam int DATA_W       = 32;
  localparam int ROW_W        = 12;
  localparam int COL_W        = 13;
  localparam int ROW_LSB      = 16;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_POL_BIT = 7;
  localparam int MSK_ERR_BIT  = 0;
  localparam int MSK_FUNC_BIT = 1;
  localparam int MSK_FRZ_BIT  = 3;
  localparam int STS_ERR_BIT  = 16;
  localparam int STS_FUNC_BIT = 17;
  localparam int CFG_EN_BIT   = 31;
  localparam int CFG_FRZ_BIT  = 30;
  localparam int VSYNC_NEEDED = 2;

  typedef enum logic [1:0] {
    W_START = 2'd0,
    W_END   = 2'd1,
    W_REF   = 2'd2,
    W_RES   = 2'd3
  } chan_word_e;

  typedef enum logic [1:0] {
    G_CTRL = 2'd0,
    G_MASK = 2'd1,
    G_STS  = 2'd2,
    G_NONE = 2'd3
  } glb_word_e;
endpackage

// File: rtl/win_chk_chan.sv
module win_chk_chan
  import win_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  chan_word_e        word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              enable,
  output logic              frozen
);
  logic             en_q, frz_q;
  logic [ROW_W-1:0] srow_q, erow_q;
  logic [COL_W-1:0] scol_q, ecol_q;
  logic [DATA_W-1:0] ref_q, res_q;
  logic unused_bits;

  assign unused_bits = ^{wdata[29:28], wdata[15:13]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; frz_q <= 1'b0;
      srow_q <= '0; scol_q <= '0; erow_q <= '0; ecol_q <= '0;
      ref_q <= '0; res_q <= '0;
    end else if (wr_en) begin
      case (word)
        W_START: begin
          frz_q <= frz_q | wdata[CFG_FRZ_BIT];
          if (!frz_q) begin
            en_q   <= wdata[CFG_EN_BIT];
            srow_q <= wdata[ROW_LSB +: ROW_W];
            scol_q <= wdata[COL_W-1:0];
          end
        end
        W_END: if (!frz_q) begin
          erow_q <= wdata[ROW_LSB +: ROW_W];
          ecol_q <= wdata[COL_W-1:0];
        end
        W_REF: if (!frz_q) ref_q <= wdata;
        default: if (!frz_q) res_q <= wdata;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (word)
      W_START: begin
        rdata[CFG_EN_BIT]           = en_q;
        rdata[CFG_FRZ_BIT]          = frz_q;
        rdata[ROW_LSB +: ROW_W]     = srow_q;
        rdata[COL_W-1:0]            = scol_q;
      end
      W_END: begin
        rdata[ROW_LSB +: ROW_W]     = erow_q;
        rdata[COL_W-1:0]            = ecol_q;
      end
      W_REF:   rdata = ref_q;
      default: rdata = res_q;
    endcase
  end

  assign enable = en_q;
  assign frozen = frz_q;

  // R12: a freeze bit never falls outside reset
  assert_chan_frz_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q |=> frz_q);
  // R11: frozen configuration holds still
  assert_chan_frz_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q |=> $stable({en_q, srow_q, scol_q, erow_q, ecol_q, ref_q, res_q}));
endmodule

// File: rtl/win_chk_status.sv
module win_chk_status #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic              vsync,
  input  logic [NUM_CH-1:0] fail_set,
  input  logic [NUM_CH-1:0] fail_clr,
  input  logic              func_clr,
  input  logic              err_mask,
  input  logic              func_mask,
  output logic [NUM_CH-1:0] fail_q,
  output logic              err_sts,
  output logic              func_q,
  output logic              irq
);
  localparam int CNT_W = $clog2(win_chk_pkg::VSYNC_NEEDED + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(win_chk_pkg::VSYNC_NEEDED);

  logic [CNT_W-1:0] vcnt_q;
  logic             func_hit;

  assign func_hit = glb_en & vsync & (vcnt_q == CNT_MAX - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= '0;
      func_q <= 1'b0;
      vcnt_q <= '0;
    end else begin
      fail_q <= (fail_q & ~fail_clr) | fail_set;
      func_q <= (func_q & ~func_clr) | func_hit;
      if (!glb_en)                      vcnt_q <= '0;
      else if (vsync && vcnt_q != CNT_MAX) vcnt_q <= vcnt_q + 1'b1;
    end
  end

  assign err_sts = |fail_q;
  assign irq     = (err_sts & err_mask) | (func_q & func_mask);

  // R3 R5: a gated pulse always leaves its bit set, even against a clear
  assert_fail_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|fail_set) |=> ((fail_q & $past(fail_set)) == $past(fail_set)));
  // R4: a bit only drops after a write-1 clear
  assert_fail_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~fail_q & $past(fail_q) & ~$past(fail_clr)) == '0));
  // R7: function status only rises while enabled
  assert_func_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(func_q) |-> $past(glb_en));
endmodule

// File: rtl/win_chk_ctrl.sv
module win_chk_ctrl
  import win_chk_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = $clog2((NUM_CH + 1) * 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              vsync,
  input  logic [NUM_CH-1:0] fail_pulse,
  output logic              glb_enable,
  output logic              clk_invert,
  output logic [NUM_CH-1:0] chan_enable,
  output logic              irq
);
  localparam int BLK_W = ADDR_W - 2;
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [BLK_W-1:0]  blk;
  logic [1:0]        word;
  logic              in_chan;
  logic [IDX_W-1:0]  ch_idx;
  glb_word_e         gsel;

  logic en_q, pol_q, emask_q, fmask_q, mfrz_q;
  logic [NUM_CH-1:0] fail_sts, frozen;
  logic              err_sts, func_sts;
  logic [DATA_W-1:0] chan_rd [NUM_CH];

  assign blk     = bus_addr[ADDR_W-1:2];
  assign word    = bus_addr[1:0];
  assign in_chan = (blk != '0) && (int'(blk) <= NUM_CH);
  assign ch_idx  = IDX_W'(blk - 1'b1);
  assign gsel    = (blk == '0) ? glb_word_e'(word) : G_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; pol_q <= 1'b0;
      emask_q <= 1'b0; fmask_q <= 1'b0; mfrz_q <= 1'b0;
    end else if (bus_wr) begin
      if (gsel == G_CTRL) begin
        en_q  <= bus_wdata[CTRL_EN_BIT];
        pol_q <= bus_wdata[CTRL_POL_BIT];
      end
      if (gsel == G_MASK) begin
        mfrz_q <= mfrz_q | bus_wdata[MSK_FRZ_BIT];
        if (!mfrz_q) begin
          emask_q <= bus_wdata[MSK_ERR_BIT];
          fmask_q <= bus_wdata[MSK_FUNC_BIT];
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    win_chk_chan i_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_wr && in_chan && (ch_idx == IDX_W'(c))),
      .word   (chan_word_e'(word)),
      .wdata  (bus_wdata),
      .rdata  (chan_rd[c]),
      .enable (chan_enable[c]),
      .frozen (frozen[c])
    );
  end

  logic sts_wr;
  assign sts_wr = bus_wr && (gsel == G_STS);

  win_chk_status #(.NUM_CH(NUM_CH)) i_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_en    (en_q),
    .vsync     (vsync),
    .fail_set  (fail_pulse & chan_enable & {NUM_CH{en_q}}),
    .fail_clr  (sts_wr ? bus_wdata[NUM_CH-1:0] : '0),
    .func_clr  (sts_wr & bus_wdata[STS_FUNC_BIT]),
    .err_mask  (emask_q),
    .func_mask (fmask_q),
    .fail_q    (fail_sts),
    .err_sts   (err_sts),
    .func_q    (func_sts),
    .irq       (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (gsel)
      G_CTRL: begin
        bus_rdata[CTRL_EN_BIT]  = en_q;
        bus_rdata[CTRL_POL_BIT] = pol_q;
      end
      G_MASK: begin
        bus_rdata[MSK_ERR_BIT]  = emask_q;
        bus_rdata[MSK_FUNC_BIT] = fmask_q;
        bus_rdata[MSK_FRZ_BIT]  = mfrz_q;
      end
      G_STS: begin
        bus_rdata[NUM_CH-1:0]   = fail_sts;
        bus_rdata[STS_ERR_BIT]  = err_sts;
        bus_rdata[STS_FUNC_BIT] = func_sts;
      end
      default: if (in_chan) bus_rdata = chan_rd[ch_idx];
    endcase
  end

  assign glb_enable = en_q;
  assign clk_invert = pol_q;

  logic unused_frz;
  assign unused_frz = ^frozen;

  // R10: frozen masks hold still
  assert_mask_frz_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mfrz_q |=> $stable({emask_q, fmask_q}));
  // R12: mask freeze never falls outside reset
  assert_mask_frz_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mfrz_q |=> mfrz_q);
endmodule

// File: tb/test_win_chk_ctrl.sv
`timescale 1ns/1ps
module test_win_chk_ctrl;
  localparam int NCH = 16;
  localparam int AW  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic vsync = 1'b0;
  logic [NCH-1:0] fail_pulse = '0;
  logic glb_enable, clk_invert, irq;
  logic [NCH-1:0] chan_enable;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_cfg [NCH][4];
  logic [NCH-1:0] m_fail;

  always #4 clk = ~clk;

  win_chk_ctrl #(.NUM_CH(NCH)) i_win_chk_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vsync(vsync),
    .fail_pulse(fail_pulse), .glb_enable(glb_enable), .clk_invert(clk_invert),
    .chan_enable(chan_enable), .irq(irq)
  );

  function automatic logic [AW-1:0] ca(int c, int w);
    return AW'((c + 1) * 4 + w);
  endfunction

  function automatic logic [31:0] word_mask(int w);
    case (w)
      0: return 32'hCFFF1FFF;
      1: return 32'h0FFF1FFF;
      default: return 32'hFFFFFFFF;
    endcase
  endfunction

  function automatic logic [31:0] exp_sts(logic [NCH-1:0] f, logic fn);
    logic [31:0] v = '0;
    v[NCH-1:0] = f;
    v[16] = |f;
    v[17] = fn;
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_fail(logic [NCH-1:0] v);
    @(negedge clk);
    fail_pulse = v;
    @(negedge clk);
    fail_pulse = '0;
  endtask

  task automatic pulse_vsync();
    @(negedge clk);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic model_wr(int c, int w, logic [31:0] d);
    if (m_cfg[c][0][30]) begin
      // frozen: only the freeze bit itself is visible, and it stays set
    end else begin
      m_cfg[c][w] = d & word_mask(w);
    end
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    rd(0, r); chk("R1 ctrl reset", r, 32'h0);
    rd(1, r); chk("R9 mask reset", r, 32'h0);
    rd(2, r); chk("R3 status reset", r, 32'h0);
    rd(ca(0, 0), r); chk("R2 chan reset", r, 32'h0);
    chk("R9 irq reset", {31'h0, irq}, 32'h0);

    // R1: control layout
    wr(0, 32'hFFFFFFFF);
    rd(0, r); chk("R1 ctrl readback", r, 32'h81);
    chk("R1 outputs", {30'h0, glb_enable, clk_invert}, 32'h3);
    wr(0, 32'h1);

    // R2: channel layout and stride
    wr(ca(3, 0), 32'hBFFFFFFF);
    rd(ca(3, 0), r); chk("R2 start word", r, 32'h8FFF1FFF);
    chk("R2 chan_enable", {16'h0, chan_enable}, 32'h0008);
    wr(ca(15, 1), 32'hFFFFFFFF);
    rd(ca(15, 1), r); chk("R2 end word", r, 32'h0FFF1FFF);
    wr(ca(0, 2), 32'h12345678);
    rd(ca(0, 2), r); chk("R2 ref word", r, 32'h12345678);
    wr(ca(7, 3), 32'hCAFEF00D);
    rd(ca(7, 3), r); chk("R2 result word", r, 32'hCAFEF00D);
    rd(ca(6, 3), r); chk("R2 neighbour untouched", r, 32'h0);

    // R3: gating by channel enable
    pulse_fail(16'h0028);
    rd(2, r); chk("R3 only enabled channel", r, exp_sts(16'h0008, 1'b0));
    // R6: bit16 read-only
    wr(2, 32'h00010000);
    rd(2, r); chk("R6 err bit read-only", r, exp_sts(16'h0008, 1'b0));
    // R9: irq from error
    wr(1, 32'h1);
    chk("R9 irq error", {31'h0, irq}, 32'h1);
    wr(1, 32'h0);
    chk("R9 irq masked", {31'h0, irq}, 32'h0);
    // R4: write 0 no effect, write 1 clears
    wr(2, 32'h0);
    rd(2, r); chk("R4 write0 keeps", r, exp_sts(16'h0008, 1'b0));
    wr(2, 32'h8);
    rd(2, r); chk("R4 w1c clears", r, exp_sts(16'h0, 1'b0));
    // R3: global enable gating
    wr(0, 32'h0);
    pulse_fail(16'h0008);
    rd(2, r); chk("R3 global disable ignores", r, exp_sts(16'h0, 1'b0));
    wr(0, 32'h1);
    // R5: set beats clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2; bus_wdata = 32'h8; fail_pulse = 16'h0008;
    @(negedge clk);
    bus_wr = 1'b0; fail_pulse = '0;
    rd(2, r); chk("R5 set wins", r, exp_sts(16'h0008, 1'b0));
    wr(2, 32'h8);

    // R7: function bit after second vsync
    wr(0, 32'h0); wr(0, 32'h1);
    pulse_vsync();
    rd(2, r); chk("R7 one vsync", r, exp_sts(16'h0, 1'b0));
    pulse_vsync();
    rd(2, r); chk("R7 two vsync", r, exp_sts(16'h0, 1'b1));
    wr(1, 32'h2);
    chk("R9 irq function", {31'h0, irq}, 32'h1);
    wr(2, 32'h00020000);
    rd(2, r); chk("R4 clear function", r, exp_sts(16'h0, 1'b0));
    chk("R9 irq after clear", {31'h0, irq}, 32'h0);
    // R8: restart on disable
    wr(0, 32'h0); wr(0, 32'h1);
    pulse_vsync();
    wr(0, 32'h0); wr(0, 32'h1);
    pulse_vsync();
    rd(2, r); chk("R8 count restarted", r, exp_sts(16'h0, 1'b0));
    pulse_vsync();
    rd(2, r); chk("R8 two fresh vsync", r, exp_sts(16'h0, 1'b1));

    // R10 R12: mask freeze
    wr(1, 32'h9);
    rd(1, r); chk("R10 freeze set", r, 32'h9);
    wr(1, 32'h2);
    rd(1, r); chk("R10 masks locked", r, 32'h9);
    // R11 R12: channel freeze
    wr(ca(3, 0), 32'hC0010002);
    rd(ca(3, 0), r); chk("R11 freeze write", r, 32'hC0010002);
    wr(ca(3, 0), 32'h00000000);
    rd(ca(3, 0), r); chk("R12 freeze sticky", r, 32'hC0010002);
    wr(ca(3, 1), 32'h00050006);
    rd(ca(3, 1), r); chk("R11 end locked", r, 32'h0);
    wr(ca(3, 2), 32'hDEADBEEF);
    rd(ca(3, 2), r); chk("R11 ref locked", r, 32'h0);
    do_reset();
    rd(ca(3, 0), r); chk("R12 reset clears channel freeze", r, 32'h0);
    rd(1, r); chk("R12 reset clears mask freeze", r, 32'h0);

    // Random phase against a bench model (R2 R3 R4 R11)
    for (int c = 0; c < NCH; c++)
      for (int w = 0; w < 4; w++) m_cfg[c][w] = '0;
    m_fail = '0;
    wr(0, 32'h1);
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 4);
      if (op == 0) begin
        int c = int'($urandom % NCH);
        int w = int'($urandom % 4);
        logic [31:0] d = $urandom;
        d[30] = (($urandom % 24) == 0);
        model_wr(c, w, d);
        if (w == 0 && d[30]) m_cfg[c][0][30] = 1'b1;
        wr(ca(c, w), d);
        rd(ca(c, w), r); chk("R11 random config", r, m_cfg[c][w]);
      end else if (op == 1) begin
        logic [NCH-1:0] p = NCH'($urandom);
        logic [NCH-1:0] en;
        for (int c = 0; c < NCH; c++) en[c] = m_cfg[c][0][31];
        m_fail = m_fail | (p & en);
        pulse_fail(p);
      end else if (op == 2) begin
        logic [31:0] d = $urandom;
        m_fail = m_fail & ~d[NCH-1:0];
        wr(2, d);
      end else begin
        rd(2, r); chk("R3 random status", r, exp_sts(m_fail, 1'b0));
      end
    end
    rd(2, r); chk("R4 final status", r, exp_sts(m_fail, 1'b0));

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule